// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits in a host bridge between a processor-side register bus and a configuration request channel. It gives the processor two windows: an index window that holds a 32-bit configuration pointer, and a data window. Every data-window access turns the stored pointer into a standard configuration address, with the bus number in bits 23..16, the device in 15..11, the function in 10..8 and the register in 7..0. It then issues one request on a valid/ready channel and returns the response to the host.

Three pointer formats are decoded. A pointer with bit 31 set is passed through unchanged, apart from its two lowest bits. A pointer with bit 0 set is handled as a type-1 address. Any other pointer is a type-0 pointer, which selects a device with a one-hot select bit in bits 31..11. The block encodes that select bit as a device number. If no select bit is set, the access has no target. A read without a target returns all ones, and a write without a target is dropped without a request.

The host side is a level request held until a one-cycle acknowledge. It carries a window select, a 3-bit offset inside the window, an access size and right-aligned data. The fabric above the block decodes the two 4 KB windows. Inside a window, only the low three offset bits matter. A four-state machine sequences each access:

- IDLE: the block waits for a host request and accepts it.
- ISSUE: a request is offered downstream.
- WAIT: the block waits for the read response.
- DONE: the acknowledge is driven.

The transitions are:

- IDLE to DONE for index-window accesses and for accesses without a target.
- IDLE to ISSUE for data accesses that have a target.
- ISSUE to DONE when a write is granted, or when a read is granted in the same cycle as its response.
- ISSUE to WAIT when a read is granted without its response.
- WAIT to DONE when the response arrives.
- DONE to IDLE always.

Top module: `pci_cfg_xlate`

## Requirements
- R1: After reset, the stored pointer is zero, `cfg_req_valid` and `host_ack` are low, and a read of the index window returns 0.
- R2: Index-window accesses (`host_win`=0) never produce a downstream request. A write replaces only the pointer bytes selected by size and offset. A read returns the pointer shifted right by 8×offset[1:0], masked to the access size.
- R3: With pointer bit 31 set, the request address is the pointer ORed with offset[1:0].
- R4: With bit 31 clear and bit 0 set, the request address is pointer bits 31..3 followed by offset[2:0].
- R5: With bits 31 and 0 both clear, the request address has the following fields:
  - bits 31..16 are zero;
  - bits 15..11 hold the index of the lowest set pointer bit in the range 31..11;
  - bits 10..3 are pointer bits 10..3;
  - bits 2..0 are offset[2:0].
- R6: A type-0 pointer with no bit set in 31..11 has no target. A data read returns all ones masked to the access size (0xFF, 0xFFFF or 0xFFFFFFFF). A data write is acknowledged without any request.
- R7: Size encoding is 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. The byte enables are 0001, 0011 or 1111 shifted left by offset[1:0]. The write data is the host data masked to the size and shifted left by 8×offset[1:0], so lanes outside the enables are zero.
- R8: Read data returned to the host is the response data shifted right by 8×offset[1:0] and masked to the access size.
- R9: The request is held with a stable address, enables, direction and data until `cfg_req_ready`. A write completes on the grant. A read completes on `cfg_rsp_valid`, which may come in the grant cycle or any later cycle.
- R10: `host_ack` is a single-cycle pulse. It comes one cycle after acceptance for accesses without a request, and one cycle after the completing grant or response otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request, held until acknowledge |
| host_win | input | 1 | 0 = index window, 1 = data window |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Byte offset inside the window |
| host_size | input | 2 | Access size code |
| host_wdata | input | 32 | Right-aligned write data |
| host_rdata | output | 32 | Right-aligned read data, valid with acknowledge |
| host_ack | output | 1 | Access complete |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Request accepted downstream |
| cfg_req_we | output | 1 | Request is a write |
| cfg_req_addr | output | 32 | Translated configuration address |
| cfg_req_be | output | 4 | Byte enables |
| cfg_req_wdata | output | 32 | Lane-aligned write data |
| cfg_rsp_valid | input | 1 | Read response valid |
| cfg_rsp_data | input | 32 | Lane-aligned read response data |

## Verification
The grant of a read request and the arrival of its response can fall in the same cycle. In that case the machine must skip WAIT, capture the response data and acknowledge on the next cycle. The bench provokes this by raising `cfg_req_ready` and `cfg_rsp_valid` together on about half of the random reads, sometimes after a random stall. It judges the result by requiring the acknowledge exactly one cycle later, with data that matches its own lane model. The other reads return the response after a random delay, and those must show no acknowledge while the response is outstanding.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } ctrl_state_e;

endpackage

// File: rtl/cfgx_index_xlate.sv
module cfgx_index_xlate #(
    parameter int W       = 32,
    parameter int SEL_LSB = 11,
    parameter int LO_W    = 3
) (
    input  logic [W-1:0]    ptr,
    input  logic [LO_W-1:0] acc_lo,
    output logic [W-1:0]    xl_addr,
    output logic            xl_hit
);
    localparam int DEV_W = $clog2(W);
    localparam int FN_LSB = SEL_LSB - 3;

    logic [DEV_W-1:0] dev_num;
    logic             dev_found;

    // Lowest set select bit wins.
    always_comb begin
        dev_num   = '0;
        dev_found = 1'b0;
        for (int i = SEL_LSB; i < W; i++) begin
            if (!dev_found && ptr[i]) begin
                dev_num   = DEV_W'(i);
                dev_found = 1'b1;
            end
        end
    end

    always_comb begin
        xl_addr = '0;
        xl_hit  = 1'b1;
        if (ptr[W-1]) begin
            xl_addr = ptr | {{(W-2){1'b0}}, acc_lo[1:0]};
        end else if (ptr[0]) begin
            xl_addr = {ptr[W-1:LO_W], acc_lo};
        end else begin
            xl_addr[SEL_LSB +: DEV_W]    = dev_num;
            xl_addr[SEL_LSB-1:FN_LSB]    = ptr[SEL_LSB-1:FN_LSB];
            xl_addr[FN_LSB-1:LO_W]       = ptr[FN_LSB-1:LO_W];
            xl_addr[LO_W-1:0]            = acc_lo;
            xl_hit                       = dev_found;
        end
    end
endmodule

// File: rtl/cfgx_wr_lane.sv
module cfgx_wr_lane
    import cfgx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]            size,
    input  logic [$clog2(W/8)-1:0] lo,
    input  logic [W-1:0]          wr_in,
    output logic [W/8-1:0]        be,
    output logic [W-1:0]          bit_mask,
    output logic [W-1:0]          wr_lane
);
    localparam int NB = W / 8;

    logic [NB-1:0] size_be;
    logic [W-1:0]  size_bits;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: size_be = NB'(1);
            SZ_HALF: size_be = NB'(3);
            default: size_be = '1;
        endcase
    end

    assign be = size_be << lo;

    for (genvar b = 0; b < NB; b++) begin : g_bytes
        assign size_bits[8*b +: 8] = {8{size_be[b]}};
        assign bit_mask[8*b +: 8]  = {8{be[b]}};
    end

    assign wr_lane = (wr_in & size_bits) << {lo, 3'b000};
endmodule

// File: rtl/cfgx_rd_lane.sv
module cfgx_rd_lane
    import cfgx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]             size,
    input  logic [$clog2(W/8)-1:0] lo,
    input  logic [W-1:0]           rd_raw,
    output logic [W-1:0]           rd_out
);
    logic [W-1:0] keep;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: keep = W'(32'h0000_00FF);
            SZ_HALF: keep = W'(32'h0000_FFFF);
            default: keep = '1;
        endcase
    end

    assign rd_out = (rd_raw >> {lo, 3'b000}) & keep;
endmodule

// File: rtl/cfgx_ctrl_fsm.sv
module cfgx_ctrl_fsm
    import cfgx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_valid,
    input  logic to_index,
    input  logic has_target,
    input  logic lat_we,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic accept,
    output logic req_valid,
    output logic ack,
    output logic take_rsp
);
    ctrl_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (host_valid) begin
                    if (to_index || !has_target) state_nx = ST_DONE;
                    else                         state_nx = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (req_ready) begin
                    if (lat_we || rsp_valid) state_nx = ST_DONE;
                    else                     state_nx = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) state_nx = ST_DONE;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = (state == ST_IDLE) && host_valid;
        req_valid = (state == ST_ISSUE);
        ack       = (state == ST_DONE);
        take_rsp  = ((state == ST_ISSUE) && req_ready && !lat_we && rsp_valid)
                  || ((state == ST_WAIT) && rsp_valid);
    end
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate #(
    parameter int W       = 32,
    parameter int SEL_LSB = 11,
    parameter int LO_W    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_valid,
    input  logic            host_win,
    input  logic            host_we,
    input  logic [LO_W-1:0] host_addr,
    input  logic [1:0]      host_size,
    input  logic [W-1:0]    host_wdata,
    output logic [W-1:0]    host_rdata,
    output logic            host_ack,
    output logic            cfg_req_valid,
    input  logic            cfg_req_ready,
    output logic            cfg_req_we,
    output logic [W-1:0]    cfg_req_addr,
    output logic [W/8-1:0]  cfg_req_be,
    output logic [W-1:0]    cfg_req_wdata,
    input  logic            cfg_rsp_valid,
    input  logic [W-1:0]    cfg_rsp_data
);
    localparam int NB   = W / 8;
    localparam int BL_W = $clog2(NB);

    logic [W-1:0]    ptr_q;
    logic            lat_we;
    logic [BL_W-1:0] lat_lo;
    logic [1:0]      lat_size;
    logic [W-1:0]    addr_q;
    logic [NB-1:0]   be_q;
    logic [W-1:0]    wdata_q;
    logic [W-1:0]    rdata_q;

    logic [W-1:0]    xl_addr;
    logic            xl_hit;
    logic [NB-1:0]   hw_be;
    logic [W-1:0]    hw_mask;
    logic [W-1:0]    hw_lane;
    logic [W-1:0]    hr_raw;
    logic [W-1:0]    hr_out;
    logic [W-1:0]    rs_out;
    logic            accept;
    logic            take_rsp;

    cfgx_index_xlate #(.W(W), .SEL_LSB(SEL_LSB), .LO_W(LO_W)) u_xlate (
        .ptr     (ptr_q),
        .acc_lo  (host_addr),
        .xl_addr (xl_addr),
        .xl_hit  (xl_hit)
    );

    cfgx_wr_lane #(.W(W)) u_wr_lane (
        .size     (host_size),
        .lo       (host_addr[BL_W-1:0]),
        .wr_in    (host_wdata),
        .be       (hw_be),
        .bit_mask (hw_mask),
        .wr_lane  (hw_lane)
    );

    // Index reads align the pointer; no-target reads align all ones.
    assign hr_raw = host_win ? '1 : ptr_q;

    cfgx_rd_lane #(.W(W)) u_rd_host (
        .size   (host_size),
        .lo     (host_addr[BL_W-1:0]),
        .rd_raw (hr_raw),
        .rd_out (hr_out)
    );

    cfgx_rd_lane #(.W(W)) u_rd_rsp (
        .size   (lat_size),
        .lo     (lat_lo),
        .rd_raw (cfg_rsp_data),
        .rd_out (rs_out)
    );

    cfgx_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .to_index   (!host_win),
        .has_target (xl_hit),
        .lat_we     (lat_we),
        .req_ready  (cfg_req_ready),
        .rsp_valid  (cfg_rsp_valid),
        .accept     (accept),
        .req_valid  (cfg_req_valid),
        .ack        (host_ack),
        .take_rsp   (take_rsp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            lat_we   <= 1'b0;
            lat_lo   <= '0;
            lat_size <= '0;
            addr_q   <= '0;
            be_q     <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
        end else begin
            if (accept) begin
                lat_we   <= host_we;
                lat_lo   <= host_addr[BL_W-1:0];
                lat_size <= host_size;
                addr_q   <= xl_addr;
                be_q     <= hw_be;
                wdata_q  <= hw_lane;
                if (!host_win) begin
                    if (host_we) ptr_q <= (ptr_q & ~hw_mask) | (hw_lane & hw_mask);
                    else         rdata_q <= hr_out;
                end else if (!xl_hit && !host_we) begin
                    rdata_q <= hr_out;
                end
            end
            if (take_rsp) rdata_q <= rs_out;
        end
    end

    assign cfg_req_we    = lat_we;
    assign cfg_req_addr  = addr_q;
    assign cfg_req_be    = be_q;
    assign cfg_req_wdata = wdata_q;
    assign host_rdata    = rdata_q;
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           host_ack,
    input logic           cfg_req_valid,
    input logic           cfg_req_ready,
    input logic           cfg_req_we,
    input logic [W-1:0]   cfg_req_addr,
    input logic [W/8-1:0] cfg_req_be,
    input logic [W-1:0]   cfg_req_wdata,
    input logic           cfg_rsp_valid
);
    a_r9_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_addr)
            && $stable(cfg_req_be) && $stable(cfg_req_we) && $stable(cfg_req_wdata));

    a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    a_r10_ack_not_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ack && cfg_req_valid));

    a_r7_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> ($countones(cfg_req_be) == 1 || $countones(cfg_req_be) == 2
                           || $countones(cfg_req_be) == 4));

    a_r9_write_done_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && cfg_req_ready && cfg_req_we |=> host_ack);

    a_r9_read_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && cfg_req_ready && !cfg_req_we && cfg_rsp_valid |=> host_ack);
endmodule

bind pci_cfg_xlate cfgx_checker #(.W(W)) u_chk (.*);

// File: tb/pci_cfg_xlate_test.sv
module pci_cfg_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_win = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ack;
    logic        cfg_req_valid;
    logic        cfg_req_ready = 1'b0;
    logic        cfg_req_we;
    logic [31:0] cfg_req_addr;
    logic [3:0]  cfg_req_be;
    logic [31:0] cfg_req_wdata;
    logic        cfg_rsp_valid = 1'b0;
    logic [31:0] cfg_rsp_data = '0;

    int checks = 0;
    int failures = 0;
    logic [31:0] ptr_model = '0;

    always #10 clk = ~clk;

    pci_cfg_xlate uut (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] f_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [3:0] f_be(input logic [1:0] sz, input logic [1:0] lo);
        logic [3:0] base;
        base = (sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111;
        return base << lo;
    endfunction

    // {hit, address}
    function automatic logic [32:0] f_xlate(input logic [31:0] p, input logic [2:0] lo);
        logic [31:0] a;
        int dev;
        if (p[31]) return {1'b1, p | {30'd0, lo[1:0]}};
        if (p[0])  return {1'b1, p[31:3], lo};
        dev = -1;
        for (int k = 31; k >= 11; k--) if (p[k]) dev = k;
        if (dev < 0) return {1'b0, 32'd0};
        a = {16'd0, 5'(dev), p[10:8], p[7:3], lo};
        return {1'b1, a};
    endfunction

    task automatic access(input logic win, input logic we, input logic [2:0] a,
                          input logic [1:0] sz, input logic [31:0] wd,
                          input logic [31:0] rsp, input bit same,
                          input int stall, input int lat);
        logic [32:0] xl;
        logic [31:0] exp_rd;
        logic [31:0] lane;
        logic [3:0]  be;
        string atag;
        string rtag;
        xl = f_xlate(ptr_model, a);
        atag = ptr_model[31] ? "R3" : (ptr_model[0] ? "R4" : "R5");
        be = f_be(sz, a[1:0]);
        lane = (wd & f_mask(sz)) << (8 * a[1:0]);
        if (!win) begin
            exp_rd = (ptr_model >> (8 * a[1:0])) & f_mask(sz);
            rtag = "R2";
        end else if (!xl[32]) begin
            exp_rd = f_mask(sz);
            rtag = "R6";
        end else begin
            exp_rd = (rsp >> (8 * a[1:0])) & f_mask(sz);
            rtag = "R8";
        end
        if (!win && we)
            for (int b = 0; b < 4; b++) if (be[b]) ptr_model[8*b +: 8] = lane[8*b +: 8];
        host_valid = 1'b1; host_win = win; host_we = we;
        host_addr = a; host_size = sz; host_wdata = wd;
        @(negedge clk);
        if (win && xl[32]) begin
            chk("R9", "req valid", 32'(cfg_req_valid), 32'd1);
            chk(atag, "req addr", cfg_req_addr, xl[31:0]);
            chk("R7", "byte enables", 32'(cfg_req_be), 32'(be));
            chk("R9", "req dir", 32'(cfg_req_we), 32'(we));
            if (we) chk("R7", "write lanes", cfg_req_wdata, lane);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk("R9", "held valid", 32'(cfg_req_valid), 32'd1);
                chk("R9", "held addr", cfg_req_addr, xl[31:0]);
            end
            cfg_req_ready = 1'b1;
            if (!we && same) begin
                cfg_rsp_valid = 1'b1; cfg_rsp_data = rsp;
            end
            @(negedge clk);
            cfg_req_ready = 1'b0; cfg_rsp_valid = 1'b0; cfg_rsp_data = $urandom;
            if (!we && !same) begin
                for (int l = 0; l < lat; l++) begin
                    chk("R9", "no ack while waiting", 32'(host_ack), 32'd0);
                    @(negedge clk);
                end
                cfg_rsp_valid = 1'b1; cfg_rsp_data = rsp;
                @(negedge clk);
                cfg_rsp_valid = 1'b0; cfg_rsp_data = $urandom;
            end
        end else begin
            chk(win ? "R6" : "R2", "no request", 32'(cfg_req_valid), 32'd0);
        end
        chk("R10", "ack", 32'(host_ack), 32'd1);
        if (!we) chk(rtag, "read data", host_rdata, exp_rd);
        host_valid = 1'b0;
        @(negedge clk);
        chk("R10", "ack pulse", 32'(host_ack), 32'd0);
    endtask

    task automatic set_ptr(input logic [31:0] p);
        access(1'b0, 1'b1, 3'd0, 2'd2, p, 32'd0, 1'b0, 0, 0);
    endtask

    function automatic logic [31:0] gen_ptr();
        logic [31:0] r;
        r = $urandom;
        case ($urandom % 5)
            0: return r | 32'h8000_0000;
            1: return (r | 32'h1) & 32'h7FFF_FFFF;
            2: return (32'h1 << (11 + $urandom % 20)) | (r & 32'h0000_07FE);
            3: return (r & 32'h7FFF_FFFE) | 32'h0010_0000;
            default: return r & 32'h0000_07FE;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [1:0] sz;
        logic [2:0] a;
        void'($urandom(32'h1D5E_7A11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset req valid", 32'(cfg_req_valid), 32'd0);
        chk("R1", "reset ack", 32'(host_ack), 32'd0);
        access(1'b0, 1'b0, 3'd0, 2'd2, 32'd0, 32'd0, 1'b0, 0, 0);   // R1 pointer reads zero

        // R6: no select bit -> ones on read, write dropped
        access(1'b1, 1'b0, 3'd1, 2'd0, 32'd0, 32'h1234_5678, 1'b0, 0, 0);
        access(1'b1, 1'b0, 3'd4, 2'd2, 32'd0, 32'h1234_5678, 1'b0, 0, 0);
        access(1'b1, 1'b1, 3'd2, 2'd1, 32'hBEEF, 32'd0, 1'b0, 0, 0);
        // R5 boundaries: lowest and highest select bits, and several bits set
        set_ptr(32'h0000_0800 | 32'h0000_0500 | 32'h0000_003C);
        access(1'b1, 1'b0, 3'd4, 2'd2, 32'd0, 32'hCAFE_F00D, 1'b1, 2, 0);
        set_ptr(32'h4000_0000);
        access(1'b1, 1'b1, 3'd6, 2'd1, 32'hFFFF_ABCD, 32'd0, 1'b0, 1, 0);
        set_ptr(32'h0010_4000 | 32'h0000_0300);
        access(1'b1, 1'b0, 3'd3, 2'd0, 32'd0, 32'hA1B2_C3D4, 1'b0, 0, 3);
        // R3 pass-through and R4 type-1
        set_ptr(32'h8000_1234);
        access(1'b1, 1'b0, 3'd3, 2'd0, 32'd0, 32'h5566_7788, 1'b0, 0, 1);
        set_ptr(32'h0001_0A05);
        access(1'b1, 1'b0, 3'd6, 2'd1, 32'd0, 32'h9ABC_DEF0, 1'b1, 0, 0);
        // R2 partial pointer write, then read back a half
        access(1'b0, 1'b1, 3'd2, 2'd0, 32'h0000_00EE, 32'd0, 1'b0, 0, 0);
        access(1'b0, 1'b0, 3'd2, 2'd1, 32'd0, 32'd0, 1'b0, 0, 0);

        for (int n = 0; n < 400; n++) begin
            sz = 2'($urandom % 3);
            a  = 3'($urandom);
            if (sz == 2'd1) a[0] = 1'b0;
            if (sz == 2'd2) a[1:0] = 2'b00;
            case ($urandom % 8)
                0: set_ptr(gen_ptr());
                1: access(1'b0, $urandom % 2 == 0, a, sz, $urandom, 32'd0, 1'b0, 0, 0);
                default: access(1'b1, $urandom % 2 == 0, a, sz, $urandom, $urandom,
                                $urandom % 2 == 0, $urandom % 4, $urandom % 4);
            endcase
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule